// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer with Watchdog Reset

This block is a register-mapped timer built around one 16-bit down-counter. A power-of-two clock divider paces the counter. A two-bit mode field selects one of four behaviours: the counter can wrap freely, reload itself periodically, fire once and halt, or act as a watchdog. In watchdog mode, expiry raises a one-cycle system reset request and latches a sticky reset-cause flag. Boot software reads that flag to learn why the system restarted.

Software programs mode and divider first, writes the reload value, and then sets the run bit in a separate write. Any write to the reload register also copies the value straight into the counter. This restarts the count, and in watchdog mode it serves as the kick. The block has two synchronous active-high resets. `sys_rst` is the reset the watchdog itself triggers: it clears the timer but keeps the cause flag. `por_rst` is the power-on reset and clears everything.

Top module: `multimode_timer`

## Requirements
- R1: While `por_rst` is high and in the cycle after it, every readable register (reload at 0x00, count at 0x04, control at 0x08, cause at 0x0C) reads 0, and `expire_pulse`, `wdt_reset_req` and `reset_cause` are low.
- R2: Reads are combinational from `bus_addr`. Offset 0x00 returns the low 16 bits of the last reload write. Offset 0x08 returns the low 8 bits of the last control write. In that byte, bit 7 is run, bits 5:4 are mode and bits 3:0 are the divider code; bit 6 is stored and returned but has no function. Upper bits read 0, and unmapped offsets read 0.
- R3: A write to offset 0x00 puts `bus_wdata[15:0]` into the counter at the same clock edge, whether or not the timer runs. It also restarts the divider phase, and no expiry can happen on that edge.
- R4: While the run bit is 0 and no reload write occurs, the count (offset 0x04) holds its value.
- R5: Divider code k (0 to 14) makes the counter step once every 2^k clocks counted from enable or from the last reload write. Code 15 makes it step once every 65536 clocks.
- R6: Mode 0 (free running): a step taken while the count is 0 sets the count to 0xFFFF and raises `expire_pulse` in the next cycle for one clock.
- R7: Mode 1 (periodic): a step at count 0 copies the reload register into the counter and raises `expire_pulse` for one clock.
- R8: Mode 2 (one-shot): a step at count 0 raises `expire_pulse` once, clears the run bit (visible at 0x08) and leaves the count at 0.
- R9: Mode 3 (watchdog): a step at count 0 raises `wdt_reset_req` and `expire_pulse` together for one clock, sets `reset_cause`, and reloads the counter.
- R10: `reset_cause` appears as bit 1 of offset 0x0C. It stays set until `por_rst`, or until software writes 0x0C with bit 1 set; writing 0 there has no effect.
- R11: In watchdog mode, reload writes made more often than the interval prevent any `wdt_reset_req`.
- R12: `sys_rst` clears reload, control, count and divider but leaves `reset_cause` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high, clears all state |
| sys_rst | input | 1 | System reset, synchronous, active high, keeps the cause flag |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| expire_pulse | output | 1 | One-cycle expiry pulse in every mode |
| wdt_reset_req | output | 1 | One-cycle reset request on watchdog expiry |
| reset_cause | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The assertions assume that software does not write the control register in the same cycle a one-shot expiry stops the timer. They also assume that reload writes carry defined data. The stimulus meets both: every control write comes while the timer is idle or well away from zero, and all write data is constant. The reference model in the bench steps the timer through every mode, uses divider codes 0, 1, 2 and 15, and reads the live count on idle cycles. It also covers kicks that arrive at irregular intervals and both reset flavours hitting a set cause flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W   = 32;
    localparam int CTRL_W   = 8;
    localparam int CAUSE_BIT = 1;
    localparam int DIV_CODE_MAX = 15;
    localparam int DIV_MAX_SHIFT = 16;

    localparam logic [7:0] OFS_RELOAD = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_CAUSE  = 8'h0C;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2,
        MODE_WATCHDOG = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      run;
        logic      spare;
        tmr_mode_e mode;
        logic [3:0] div_code;
    } tmr_ctrl_t;

    typedef struct packed {
        logic      fire;
        tmr_mode_e mode;
    } tmr_evt_t;

    // log2 of the division ratio selected by a divider code
    function automatic int div_shift(input logic [3:0] code);
        if (int'(code) == DIV_CODE_MAX) return DIV_MAX_SHIFT;
        return int'(code);
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              oneshot_stop,
    input  logic [CNT_W-1:0]  count,
    input  logic              cause,
    output tmr_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              kick,
    output logic [CNT_W-1:0]  kick_value,
    output logic              cause_clr,
    output logic              ctrl_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFS_CAUSE);

    always_comb begin
        kick       = bus_we && (bus_addr == A_RELOAD);
        ctrl_wr    = bus_we && (bus_addr == A_CTRL);
        cause_clr  = bus_we && (bus_addr == A_CAUSE) && bus_wdata[CAUSE_BIT];
        kick_value = bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
        end else begin
            if (kick) reload <= kick_value;
            if (ctrl_wr) begin
                ctrl <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end else if (oneshot_stop) begin
                ctrl.run <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_RELOAD: bus_rdata = DATA_W'(reload);
            A_COUNT:  bus_rdata = DATA_W'(count);
            A_CTRL:   bus_rdata = DATA_W'(ctrl);
            A_CAUSE:  bus_rdata[CAUSE_BIT] = cause;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [3:0] div_code,
    output logic       tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W:0]   wide_mask;
    logic [PRE_W-1:0] mask;
    int               shift;

    always_comb begin
        shift = div_shift(div_code);
        if (shift > PRE_W) shift = PRE_W;
        wide_mask = ({{PRE_W{1'b0}}, 1'b1} << shift) - 1'b1;
        mask      = wide_mask[PRE_W-1:0];
        tick      = run && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart) phase_q <= '0;
        else                        phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             kick,
    input  logic [CNT_W-1:0] kick_value,
    input  logic [CNT_W-1:0] reload,
    input  tmr_mode_e        mode,
    output logic [CNT_W-1:0] count,
    output tmr_evt_t         evt,
    output logic             oneshot_stop,
    output logic             expire_pulse,
    output logic             wdt_reset_req
);

    logic             at_zero;
    logic [CNT_W-1:0] count_d;

    always_comb begin
        at_zero      = (count == '0);
        evt.fire     = tick && at_zero && !kick;
        evt.mode     = mode;
        oneshot_stop = evt.fire && (mode == MODE_ONESHOT);
    end

    always_comb begin
        count_d = count;
        if (kick) begin
            count_d = kick_value;
        end else if (tick) begin
            if (!at_zero) begin
                count_d = count - 1'b1;
            end else begin
                unique case (mode)
                    MODE_FREE:     count_d = '1;
                    MODE_PERIODIC: count_d = reload;
                    MODE_ONESHOT:  count_d = '0;
                    MODE_WATCHDOG: count_d = reload;
                    default:       count_d = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count         <= '0;
            expire_pulse  <= 1'b0;
            wdt_reset_req <= 1'b0;
        end else begin
            count         <= count_d;
            expire_pulse  <= evt.fire;
            wdt_reset_req <= evt.fire && (evt.mode == MODE_WATCHDOG);
        end
    end

endmodule

// File: rtl/tmr_cause.sv
module tmr_cause
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     por_rst,
    input  tmr_evt_t evt,
    input  logic     clr,
    output logic     cause
);

    always_ff @(posedge clk) begin
        if (por_rst)                                       cause <= 1'b0;
        else if (evt.fire && evt.mode == MODE_WATCHDOG)    cause <= 1'b1;
        else if (clr)                                      cause <= 1'b0;
    end

endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              expire_pulse,
    output logic              wdt_reset_req,
    output logic              reset_cause
);

    logic             timer_rst;
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] kick_value;
    logic             kick;
    logic             cause_clr;
    logic             ctrl_wr;
    logic             oneshot_stop;
    logic             tick;
    tmr_evt_t         evt;

    assign timer_rst = por_rst || sys_rst;

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst          (timer_rst),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .oneshot_stop (oneshot_stop),
        .count        (count_q),
        .cause        (reset_cause),
        .ctrl         (ctrl_q),
        .reload       (reload_q),
        .kick         (kick),
        .kick_value   (kick_value),
        .cause_clr    (cause_clr),
        .ctrl_wr      (ctrl_wr),
        .bus_rdata    (bus_rdata)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (timer_rst),
        .run      (ctrl_q.run),
        .restart  (kick),
        .div_code (ctrl_q.div_code),
        .tick     (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst           (timer_rst),
        .tick          (tick),
        .kick          (kick),
        .kick_value    (kick_value),
        .reload        (reload_q),
        .mode          (ctrl_q.mode),
        .count         (count_q),
        .evt           (evt),
        .oneshot_stop  (oneshot_stop),
        .expire_pulse  (expire_pulse),
        .wdt_reset_req (wdt_reset_req)
    );

    tmr_cause u_cause (
        .clk     (clk),
        .por_rst (por_rst),
        .evt     (evt),
        .clr     (cause_clr),
        .cause   (reset_cause)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              por_rst,
    input logic              sys_rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              expire_pulse,
    input logic              wdt_reset_req,
    input logic              reset_cause,
    input logic              run,
    input tmr_mode_e         mode,
    input logic [CNT_W-1:0]  count
);

    logic kick_w;
    logic ctrl_w;
    logic clr_w;
    assign kick_w = bus_we && (bus_addr == ADDR_W'(OFS_RELOAD));
    assign ctrl_w = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign clr_w  = bus_we && (bus_addr == ADDR_W'(OFS_CAUSE)) && bus_wdata[CAUSE_BIT];

    // R9
    wdt_req_with_pulse_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        wdt_reset_req |-> expire_pulse);

    // R9
    wdt_sets_cause_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        wdt_reset_req |-> reset_cause);

    // R10
    cause_only_sw_clear_chk: assert property (@(posedge clk) disable iff (por_rst)
        $fell(reset_cause) |-> $past(clr_w));

    // R4
    halt_holds_count_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        (!run && !kick_w) |=> $stable(count));

    // R3
    kick_loads_count_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        kick_w |=> (count == $past(bus_wdata[CNT_W-1:0])));

    // R8
    oneshot_halts_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        (expire_pulse && mode == MODE_ONESHOT && !$past(ctrl_w)) |-> !run);

endmodule

bind multimode_timer tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .por_rst       (por_rst),
    .sys_rst       (sys_rst),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .expire_pulse  (expire_pulse),
    .wdt_reset_req (wdt_reset_req),
    .reset_cause   (reset_cause),
    .run           (ctrl_q.run),
    .mode          (ctrl_q.mode),
    .count         (count_q)
);

// File: tb/multimode_timer_bench.sv
`timescale 1ns/1ps
module multimode_timer_bench;

    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        sys_rst = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h04;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        expire_pulse;
    logic        wdt_reset_req;
    logic        reset_cause;

    always #2.5 clk = ~clk;

    multimode_timer u_multimode_timer (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .expire_pulse(expire_pulse),
        .wdt_reset_req(wdt_reset_req), .reset_cause(reset_cause)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    int unsigned m_load, m_cnt, m_pre, m_ctrl;
    bit          m_exp, m_req, m_cause;

    function automatic int unsigned m_read(input int unsigned a);
        case (a)
            32'h00: return m_load;
            32'h04: return m_cnt;
            32'h08: return m_ctrl;
            32'h0C: return m_cause ? 32'h2 : 32'h0;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic cyc();
        int unsigned n_load, n_cnt, n_pre, n_ctrl, period;
        bit n_exp, n_req, n_cause, run, kick, tick, fire;
        int unsigned mode, code;
        n_load = m_load; n_cnt = m_cnt; n_pre = m_pre; n_ctrl = m_ctrl;
        n_cause = m_cause; n_exp = 0; n_req = 0;
        if (por_rst) begin
            n_load = 0; n_cnt = 0; n_pre = 0; n_ctrl = 0; n_cause = 0;
        end else if (sys_rst) begin
            n_load = 0; n_cnt = 0; n_pre = 0; n_ctrl = 0;
        end else begin
            run  = m_ctrl[7];
            mode = (m_ctrl >> 4) & 3;
            code = m_ctrl & 15;
            period = (code == 15) ? 65536 : (1 << code);
            kick = bus_we && bus_addr == 8'h00;
            tick = run && ((m_pre + 1) % period == 0);
            fire = tick && m_cnt == 0 && !kick;
            n_pre = (!run || kick) ? 0 : (m_pre + 1) % 65536;
            if (kick) begin
                n_cnt = bus_wdata & 32'hFFFF;
                n_load = n_cnt;
            end else if (tick) begin
                if (m_cnt != 0) n_cnt = m_cnt - 1;
                else if (mode == 0) n_cnt = 16'hFFFF;
                else if (mode == 2) n_cnt = 0;
                else n_cnt = m_load;
            end
            if (bus_we && bus_addr == 8'h08) n_ctrl = bus_wdata & 32'hFF;
            else if (fire && mode == 2) n_ctrl = m_ctrl & 32'h7F;
            n_exp = fire;
            n_req = fire && mode == 3;
            if (n_req) n_cause = 1;
            else if (bus_we && bus_addr == 8'h0C && bus_wdata[1]) n_cause = 0;
        end
        @(posedge clk);
        #1;
        cycles++;
        m_load = n_load; m_cnt = n_cnt; m_pre = n_pre; m_ctrl = n_ctrl;
        m_exp = n_exp; m_req = n_req; m_cause = n_cause;
        check("rdata", bus_rdata, m_read(bus_addr));
        check("expire_pulse", expire_pulse, m_exp);
        check("wdt_reset_req", wdt_reset_req, m_req);
        check("reset_cause", reset_cause, m_cause);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_we = 0; bus_addr = 8'h04; bus_wdata = '0;
    endtask

    task automatic idle(input int n, input logic [7:0] a);
        bus_addr = a;
        for (int i = 0; i < n; i++) cyc();
        bus_addr = 8'h04;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, LIMIT);
        finish_run();
    end

    initial begin
        #1;
        // R1: reset state of every register and output
        tag = "R1";
        idle(3, 8'h04);
        por_rst = 0;
        idle(1, 8'h00); idle(1, 8'h04); idle(1, 8'h08); idle(1, 8'h0C);

        // R2: readback widths and unmapped offset; R10 write 1 while clear
        tag = "R2";
        wr(8'h00, 32'hABCD_1234);
        idle(1, 8'h00);
        wr(8'h08, 32'hFFFF_FF4A);
        idle(1, 8'h08);
        idle(1, 8'h10);
        tag = "R10";
        wr(8'h0C, 32'hFFFF_FFFF);
        idle(1, 8'h0C);

        // R3: load writes land in the count while halted
        tag = "R3";
        idle(1, 8'h04);
        wr(8'h00, 32'h0000_0042);
        idle(2, 8'h04);

        // R4: count holds while halted
        tag = "R4";
        idle(10, 8'h04);

        // R6 and R5: free running, divide by 2 then by 1
        tag = "R6";
        wr(8'h08, 32'h01);
        wr(8'h00, 32'h3);
        wr(8'h08, 32'h81);
        idle(20, 8'h04);
        tag = "R5";
        wr(8'h08, 32'h80);
        idle(6, 8'h04);
        tag = "R4";
        wr(8'h08, 32'h00);
        idle(6, 8'h04);

        // R7: periodic reload
        tag = "R7";
        wr(8'h08, 32'h10);
        wr(8'h00, 32'h4);
        wr(8'h08, 32'h90);
        idle(20, 8'h04);
        idle(1, 8'h00);

        // R8: one-shot stops and clears run
        tag = "R8";
        wr(8'h08, 32'h22);
        wr(8'h00, 32'h2);
        wr(8'h08, 32'hA2);
        idle(20, 8'h04);
        idle(2, 8'h08);
        idle(5, 8'h04);

        // R5: largest divider code
        tag = "R5";
        wr(8'h08, 32'h0F);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h8F);
        idle(65540, 8'h04);
        wr(8'h08, 32'h00);

        // R11: watchdog kicked at irregular intervals never resets
        tag = "R11";
        wr(8'h08, 32'h32);
        wr(8'h00, 32'h5);
        wr(8'h08, 32'hB2);
        for (int k = 0; k < 10; k++) begin
            idle(8 + (k % 3) * 3, 8'h04);
            wr(8'h00, 32'h5);
        end

        // R9: missed kick raises the reset request and cause
        tag = "R9";
        idle(40, 8'h04);
        idle(1, 8'h0C);

        // R12: system reset clears timer, keeps cause
        tag = "R12";
        sys_rst = 1;
        idle(2, 8'h08);
        sys_rst = 0;
        idle(1, 8'h08); idle(1, 8'h00); idle(1, 8'h04); idle(1, 8'h0C);

        // R10: write 0 keeps cause, write 1 clears it
        tag = "R10";
        wr(8'h0C, 32'h0000_0000);
        idle(2, 8'h0C);
        wr(8'h0C, 32'h0000_0002);
        idle(2, 8'h0C);

        // R9 again with divide by 1, then R1 power-on clear of cause
        tag = "R9";
        wr(8'h08, 32'h30);
        wr(8'h00, 32'h1);
        wr(8'h08, 32'hB0);
        idle(8, 8'h0C);
        tag = "R1";
        por_rst = 1;
        idle(2, 8'h0C);
        por_rst = 0;
        idle(2, 8'h0C);

        finish_run();
    end

endmodule